// File: doc/BRIEF.md
# Radio Transmit Frame Builder

This block assembles a complete radio frame, one byte at a time, for a byte-wide serial transmit path. The request gives a payload length. The block then sends a run of preamble bytes, a two-byte sync word and a two-byte header. Next it forwards the payload bytes from an upstream source, appends a 16-bit checksum and closes the frame with two tail bytes. The downstream serialiser takes the bytes over a valid/ready handshake and may stall the frame at any byte.

The header holds a zero flag byte and a length byte. The length byte counts the header, the payload and the checksum together. The checksum is seeded with the 16-bit value (payload length + 2) before it absorbs the payload bytes. A request whose length is above the configured maximum is refused. The block flags an error and sends nothing.

Top module: `rf_frame_builder`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `busy_o`, `out_valid_o`, `pay_ready_o`, `err_o` and `done_o` are all low.
- R2: An accepted frame (`start_i` high while idle, `len_i` <= MAX_PAYLOAD) starts with PRE_COUNT bytes of 0xAA. These are followed by the sync bytes 0xD3 and then 0x91.
- R3: After the sync word come the header bytes. The first is 0x00. The second is (payload length + 4) mod 256.
- R4: Payload bytes are forwarded unchanged and in order from `pay_data_i`. `pay_ready_o` is high only in the payload phase and only while `out_ready_i` is high. A payload byte moves when `pay_valid_i` and `pay_ready_o` are both high.
- R5: The checksum follows the payload and is sent high byte first. It is computed on a 16-bit register that starts at 0xFFFF. Each byte is taken least significant bit first. For each bit, the register shifts right one place, and it is XORed with 0x8408 when the bit XOR the old register bit 0 is 1. The register absorbs the low byte of (length + 2), then the high byte of (length + 2), then each payload byte.
- R6: Two bytes of TAIL_BYTE end the frame.
- R7: `done_o` pulses high for exactly one cycle, in the cycle after the last tail byte is taken. `busy_o` is low in that same cycle.
- R8: A request with `len_i` > MAX_PAYLOAD gives a one-cycle `err_o` pulse in the next cycle. The block stays idle and emits no byte.
- R9: `start_i` is ignored while `busy_o` is high. The frame in progress is unchanged and no error is raised.
- R10: While `out_valid_o` is high and `out_ready_i` is low, the same byte stays on `out_data_o` with `out_valid_o` high in the next cycle. In the payload phase this holds only while the source holds its byte.
- R11: A zero-length request gives a frame with no payload bytes (length byte 0x04). A request with length exactly MAX_PAYLOAD is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame request, sampled while idle |
| len_i | input | LEN_W | Payload length for the request |
| pay_valid_i | input | 1 | Payload byte available |
| pay_data_i | input | 8 | Payload byte |
| pay_ready_o | output | 1 | Payload byte taken this cycle when valid |
| out_valid_o | output | 1 | Frame byte available to the serialiser |
| out_data_o | output | 8 | Frame byte |
| out_ready_i | input | 1 | Serialiser takes the byte |
| busy_o | output | 1 | A frame is in progress |
| err_o | output | 1 | One-cycle pulse: request refused as too long |
| done_o | output | 1 | One-cycle pulse: frame finished |

## Verification
A wrong phase or byte index shows on `out_data_o` at the next byte taken: a preamble that is too short or too long, a misplaced sync byte, or a length byte off by the header size. The scoreboard catches each of these at the first bad byte. A checksum register that was seeded or stepped wrongly stays hidden until the two checksum bytes appear after the payload. That can be up to MAX_PAYLOAD bytes after the fault. Long and short frames, with and without stalls, are therefore compared byte by byte. A lost or extra transition at the end shows as a missing or early `done_o` pulse against an empty queue of expected bytes.

// File: rtl/rf_frame_pkg.sv
package rf_frame_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_PRE  = 3'd1,
        PH_SYNC = 3'd2,
        PH_HDR  = 3'd3,
        PH_PAY  = 3'd4,
        PH_CRC  = 3'd5,
        PH_TAIL = 3'd6
    } phase_t;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } beat_t;

    localparam logic [7:0]  PRE_BYTE   = 8'hAA;
    localparam logic [7:0]  SYNC_FIRST = 8'hD3;
    localparam logic [7:0]  SYNC_NEXT  = 8'h91;
    localparam logic [7:0]  FLAG_BYTE  = 8'h00;
    localparam logic [15:0] CRC_SEED   = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_R = 16'h8408;
    localparam int          HDR_BYTES  = 2;
    localparam int          CRC_BYTES  = 2;

    // one byte into the reflected checksum, bit 0 first
    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY_R;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/rf_frame_ctrl.sv
module rf_frame_ctrl
    import rf_frame_pkg::*;
#(
    parameter int PRE_COUNT   = 4,
    parameter int MAX_PAYLOAD = 64,
    parameter int LEN_W       = 8,
    parameter int IDX_W       = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             xfer_i,
    output phase_t           phase_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [LEN_W-1:0] len_o,
    output logic             load_o,
    output logic             err_o,
    output logic             done_o
);
    phase_t           phase_q, phase_n;
    logic [IDX_W-1:0] idx_q;
    logic [LEN_W-1:0] len_q;
    logic             err_q, done_q;
    logic             last;
    logic             accept, refuse;

    assign accept = (phase_q == PH_IDLE) && start_i && (int'(len_i) <= MAX_PAYLOAD);
    assign refuse = (phase_q == PH_IDLE) && start_i && (int'(len_i) >  MAX_PAYLOAD);

    always_comb begin
        case (phase_q)
            PH_PRE:  last = (int'(idx_q) == PRE_COUNT - 1);
            PH_PAY:  last = (int'(idx_q) == int'(len_q) - 1);
            default: last = (idx_q[0] == 1'b1);
        endcase
    end

    always_comb begin
        case (phase_q)
            PH_PRE:  phase_n = PH_SYNC;
            PH_SYNC: phase_n = PH_HDR;
            PH_HDR:  phase_n = (len_q == '0) ? PH_CRC : PH_PAY;
            PH_PAY:  phase_n = PH_CRC;
            PH_CRC:  phase_n = PH_TAIL;
            default: phase_n = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            len_q   <= '0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            err_q  <= refuse;
            done_q <= 1'b0;
            if (accept) begin
                len_q   <= len_i;
                idx_q   <= '0;
                phase_q <= PH_PRE;
            end else if (phase_q != PH_IDLE && xfer_i) begin
                if (last) begin
                    idx_q   <= '0;
                    phase_q <= phase_n;
                    done_q  <= (phase_q == PH_TAIL);
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    assign phase_o = phase_q;
    assign idx_o   = idx_q;
    assign len_o   = len_q;
    assign load_o  = accept;
    assign err_o   = err_q;
    assign done_o  = done_q;
endmodule

// File: rtl/rf_frame_crc.sv
module rf_frame_crc
    import rf_frame_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             upd_i,
    input  logic [7:0]       byte_i,
    output logic [15:0]      crc_o
);
    logic [15:0] crc_q;
    logic [15:0] seed_cnt;

    assign seed_cnt = 16'(len_i) + 16'(HDR_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= CRC_SEED;
        end else if (load_i) begin
            crc_q <= crc_step(crc_step(CRC_SEED, seed_cnt[7:0]), seed_cnt[15:8]);
        end else if (upd_i) begin
            crc_q <= crc_step(crc_q, byte_i);
        end
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/rf_frame_mux.sv
module rf_frame_mux
    import rf_frame_pkg::*;
#(
    parameter int         LEN_W     = 8,
    parameter logic [7:0] TAIL_BYTE = 8'h7E
) (
    input  phase_t           phase_i,
    input  logic             second_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [15:0]      crc_i,
    input  logic             pay_valid_i,
    input  logic [7:0]       pay_data_i,
    input  logic             out_ready_i,
    output beat_t            beat_o,
    output logic             pay_ready_o
);
    logic [7:0] len_byte;

    assign len_byte = 8'(len_i) + 8'(HDR_BYTES + CRC_BYTES);

    always_comb begin
        beat_o      = '0;
        pay_ready_o = 1'b0;
        case (phase_i)
            PH_PRE: begin
                beat_o.valid = 1'b1;
                beat_o.data  = PRE_BYTE;
            end
            PH_SYNC: begin
                beat_o.valid = 1'b1;
                beat_o.data  = second_i ? SYNC_NEXT : SYNC_FIRST;
            end
            PH_HDR: begin
                beat_o.valid = 1'b1;
                beat_o.data  = second_i ? len_byte : FLAG_BYTE;
            end
            PH_PAY: begin
                beat_o.valid = pay_valid_i;
                beat_o.data  = pay_data_i;
                pay_ready_o  = out_ready_i;
            end
            PH_CRC: begin
                beat_o.valid = 1'b1;
                beat_o.data  = second_i ? crc_i[7:0] : crc_i[15:8];
            end
            PH_TAIL: begin
                beat_o.valid = 1'b1;
                beat_o.data  = TAIL_BYTE;
            end
            default: beat_o = '0;
        endcase
    end
endmodule

// File: rtl/rf_frame_builder.sv
module rf_frame_builder
    import rf_frame_pkg::*;
#(
    parameter int         PRE_COUNT   = 4,
    parameter int         MAX_PAYLOAD = 64,
    parameter int         LEN_W       = 8,
    parameter logic [7:0] TAIL_BYTE   = 8'h7E
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             pay_valid_i,
    input  logic [7:0]       pay_data_i,
    output logic             pay_ready_o,
    output logic             out_valid_o,
    output logic [7:0]       out_data_o,
    input  logic             out_ready_i,
    output logic             busy_o,
    output logic             err_o,
    output logic             done_o
);
    localparam int SPAN  = (PRE_COUNT > MAX_PAYLOAD) ? PRE_COUNT : MAX_PAYLOAD;
    localparam int IDX_W = (SPAN < 2) ? 1 : $clog2(SPAN + 1);

    phase_t           phase_w;
    logic [IDX_W-1:0] idx_w;
    logic [LEN_W-1:0] len_w;
    logic             load_w;
    logic [15:0]      crc_w;
    beat_t            beat_w;
    logic             xfer_w;
    logic             pay_take_w;

    assign xfer_w     = beat_w.valid && out_ready_i;
    assign pay_take_w = pay_valid_i && pay_ready_o;

    rf_frame_ctrl #(
        .PRE_COUNT  (PRE_COUNT),
        .MAX_PAYLOAD(MAX_PAYLOAD),
        .LEN_W      (LEN_W),
        .IDX_W      (IDX_W)
    ) ctrl_i (
        .clk    (clk),
        .rst    (rst),
        .start_i(start_i),
        .len_i  (len_i),
        .xfer_i (xfer_w),
        .phase_o(phase_w),
        .idx_o  (idx_w),
        .len_o  (len_w),
        .load_o (load_w),
        .err_o  (err_o),
        .done_o (done_o)
    );

    rf_frame_crc #(
        .LEN_W(LEN_W)
    ) crc_i (
        .clk   (clk),
        .rst   (rst),
        .load_i(load_w),
        .len_i (len_i),
        .upd_i (pay_take_w),
        .byte_i(pay_data_i),
        .crc_o (crc_w)
    );

    rf_frame_mux #(
        .LEN_W    (LEN_W),
        .TAIL_BYTE(TAIL_BYTE)
    ) mux_i (
        .phase_i    (phase_w),
        .second_i   (idx_w[0]),
        .len_i      (len_w),
        .crc_i      (crc_w),
        .pay_valid_i(pay_valid_i),
        .pay_data_i (pay_data_i),
        .out_ready_i(out_ready_i),
        .beat_o     (beat_w),
        .pay_ready_o(pay_ready_o)
    );

    assign out_valid_o = beat_w.valid;
    assign out_data_o  = beat_w.data;
    assign busy_o      = (phase_w != PH_IDLE);
endmodule

// File: rtl/rf_frame_builder_chk.sv
module rf_frame_builder_chk
    import rf_frame_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       busy_o,
    input logic       err_o,
    input logic       done_o,
    input logic       out_valid_o,
    input logic       out_ready_i,
    input logic [7:0] out_data_o,
    input logic       pay_ready_o,
    input phase_t     phase
);
    a_r4_ready_gated: assert property (@(posedge clk) disable iff (rst)
        pay_ready_o |-> (out_ready_i && busy_o));

    a_r8_err_idle: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (!busy_o && !out_valid_o));

    a_r7_done_end: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o)));

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r9_busy_start_no_err: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> !err_o);

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !out_ready_i && phase != PH_PAY) |=> (out_valid_o && $stable(out_data_o)));
endmodule

bind rf_frame_builder rf_frame_builder_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .err_o      (err_o),
    .done_o     (done_o),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .out_data_o (out_data_o),
    .pay_ready_o(pay_ready_o),
    .phase      (phase_w)
);

// File: tb/rf_frame_builder_tb_top.sv
module rf_frame_builder_tb_top;
    localparam int         PRE  = 4;
    localparam int         MAXP = 32;
    localparam int         LW   = 8;
    localparam logic [7:0] TAIL = 8'h7E;

    logic          clk = 1'b0;
    logic          rst;
    logic          start_i;
    logic [LW-1:0] len_i;
    logic          pay_valid_i;
    logic [7:0]    pay_data_i;
    logic          pay_ready_o;
    logic          out_valid_o;
    logic [7:0]    out_data_o;
    logic          out_ready_i;
    logic          busy_o, err_o, done_o;

    always #10 clk = ~clk;

    rf_frame_builder #(
        .PRE_COUNT(PRE), .MAX_PAYLOAD(MAXP), .LEN_W(LW), .TAIL_BYTE(TAIL)
    ) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i),
        .pay_valid_i(pay_valid_i), .pay_data_i(pay_data_i), .pay_ready_o(pay_ready_o),
        .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_ready_i(out_ready_i),
        .busy_o(busy_o), .err_o(err_o), .done_o(done_o)
    );

    int         checks = 0;
    int         fails  = 0;
    logic [7:0] exp_q[$];
    logic [7:0] pay_mem[0:255];
    logic [15:0] lfsr = 16'hACE1;
    bit         finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            logic fb;
            fb = r[0] ^ b[i];
            r  = {1'b0, r[15:1]};
            if (fb) r = r ^ 16'h8408;
        end
        return r;
    endfunction

    // driver side of the scoreboard: expected frame bytes
    task automatic push_frame(input int len);
        logic [15:0] c;
        logic [15:0] cnt;
        cnt = 16'(len + 2);
        c = ref_crc(16'hFFFF, cnt[7:0]);
        c = ref_crc(c, cnt[15:8]);
        for (int i = 0; i < PRE; i++) exp_q.push_back(8'hAA);
        exp_q.push_back(8'hD3);
        exp_q.push_back(8'h91);
        exp_q.push_back(8'h00);
        exp_q.push_back(8'(len + 4));
        for (int i = 0; i < len; i++) begin
            exp_q.push_back(pay_mem[i]);
            c = ref_crc(c, pay_mem[i]);
        end
        exp_q.push_back(c[15:8]);
        exp_q.push_back(c[7:0]);
        exp_q.push_back(TAIL);
        exp_q.push_back(TAIL);
    endtask

    // monitor side: pop and compare each byte taken
    logic       prev_stall = 1'b0;
    logic [7:0] prev_data  = 8'h00;
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (!rst) begin
                if (prev_stall)
                    check(out_valid_o && out_data_o == prev_data, "R10 held byte",
                          int'(out_data_o), int'(prev_data));
                if (out_valid_o && out_ready_i) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R2 R6 unexpected byte", int'(out_data_o), 0);
                    end else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        check(out_data_o == e, "R2 R3 R4 R5 R6 frame byte", int'(out_data_o), int'(e));
                    end
                end
                prev_stall = out_valid_o && !out_ready_i;
                prev_data  = out_data_o;
            end
        end
    end

    task automatic run_frame(input int len, input int rmode, input int vmode,
                             input int inject_at, input int seed);
        int  pidx;
        bit  pending;
        bit  ready_bad;
        bit  seen_done;
        pidx = 0; pending = 0; ready_bad = 0; seen_done = 0;
        for (int i = 0; i < 256; i++) pay_mem[i] = 8'(i * 37 + seed);
        @(negedge clk);
        start_i = 1'b1; len_i = LW'(len); out_ready_i = 1'b0; pay_valid_i = 1'b0;
        push_frame(len);
        for (int cyc = 0; cyc < 3000; cyc++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (cyc == inject_at) begin
                start_i = 1'b1;
                len_i   = LW'(3);
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready_i = (rmode != 0) ? lfsr[0] : 1'b1;
            if (!pending) pay_valid_i = (vmode != 0) ? lfsr[3] : 1'b1;
            pay_data_i = pay_mem[pidx];
            #1;
            if (cyc == 0)
                check(busy_o == 1'b1, "R11 request accepted (len boundary)", int'(busy_o), 1);
            if (pay_ready_o && !out_ready_i) ready_bad = 1;
            if (done_o) begin
                check(exp_q.size() == 0, "R7 done after last byte", exp_q.size(), 0);
                check(busy_o == 1'b0, "R7 idle with done", int'(busy_o), 0);
                seen_done = 1;
                break;
            end
            pending = pay_valid_i && !pay_ready_o;
            if (pay_valid_i && pay_ready_o) pidx++;
        end
        check(seen_done, "R7 done seen", int'(seen_done), 1);
        check(!ready_bad, "R4 pay_ready gated by out_ready", int'(ready_bad), 0);
        check(pidx == len, "R4 payload bytes taken", pidx, len);
        @(negedge clk);
        start_i = 1'b0; out_ready_i = 1'b0; pay_valid_i = 1'b0;
        #1;
        check(done_o == 1'b0, "R7 done single pulse", int'(done_o), 0);
        exp_q.delete();
    endtask

    task automatic refuse(input int len);
        @(negedge clk);
        start_i = 1'b1; len_i = LW'(len); out_ready_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        #1;
        check(err_o == 1'b1, "R8 err pulse", int'(err_o), 1);
        check(!busy_o && !out_valid_o, "R8 stays idle", int'(busy_o), 0);
        @(negedge clk);
        #1;
        check(err_o == 1'b0, "R8 err one cycle", int'(err_o), 0);
        check(!busy_o && !out_valid_o, "R8 no frame", int'(out_valid_o), 0);
        out_ready_i = 1'b0;
    endtask

    initial begin
        rst = 1'b1; start_i = 1'b0; len_i = '0; pay_valid_i = 1'b0;
        pay_data_i = '0; out_ready_i = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(!busy_o && !out_valid_o && !pay_ready_o && !err_o && !done_o,
              "R1 reset state", int'({busy_o, out_valid_o, pay_ready_o, err_o, done_o}), 0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(!busy_o && !out_valid_o && !done_o, "R1 after reset", int'(busy_o), 0);

        run_frame(5, 0, 0, -1, 1);
        run_frame(0, 1, 0, -1, 2);      // R11 empty payload
        run_frame(MAXP, 1, 1, -1, 3);   // R11 largest payload
        refuse(MAXP + 1);
        refuse(200);
        run_frame(1, 1, 0, 3, 4);       // R9 start while busy
        run_frame(12, 0, 1, 8, 5);      // R9 start in payload phase
        run_frame(7, 1, 1, -1, 6);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule